// File: doc/BRIEF.md
# Store Buffer with Result-Broadcast Snoop

This block holds outstanding store operations between issue and the memory write port. Each issued store brings two address parts, a base and an offset, and either its data value or the tag of the execution station that will produce that value. A shared adder forms the effective address of one waiting entry per cycle. The entry then keeps the finished destination address until the store retires.

While an entry carries a non-zero producer tag, it watches the result broadcast bus. When a result appears with that tag, the entry takes the broadcast data and clears its tag. A tag of zero always means the stored value is already valid. Stores drain to memory strictly in issue order. Only the oldest entry can request a write, and only once its address is formed and its value is valid. The entry is released when memory acknowledges the request. Issue stalls while every entry is occupied.

Top module: `store_buffer`

## Requirements
- R1: In the first cycle after reset, `iss_ready` is 1 and `mem_valid` is 0.
- R2: The address written to memory is `iss_base + iss_offset`, modulo 2^ADDR_W. Carries out of the top bit are dropped.
- R3: A store issued with `iss_tag` = 0 writes `iss_data` to memory.
- R4: A store issued with a non-zero `iss_tag` does not request a write until a broadcast with `bc_valid`=1 and `bc_tag` equal to that tag arrives. It then writes that broadcast's `bc_data`. Every waiting entry that holds the tag captures the data.
- R5: A broadcast whose tag differs from an entry's producer tag does not change that entry. The entry keeps waiting.
- R6: A store is issued with a non-zero tag, and in that same cycle a broadcast carries that tag. The store captures the broadcast data and needs no later broadcast.
- R7: Memory writes occur in issue order. A younger store whose value is ready never writes ahead of an older store that is still waiting.
- R8: While `mem_valid` is 1 and `mem_ack` is 0, the request stays asserted and `mem_addr` and `mem_data` stay unchanged. A cycle with both signals high retires exactly one store.
- R9: With DEPTH stores outstanding, `iss_ready` is 0. An `iss_valid` pulse during that time is discarded and never reaches memory.
- R10: Take a store issued at clock edge k into an empty buffer with its value ready. `mem_valid` is 0 after edge k and 1 after edge k+1, which is the edge where its address is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request for a new store |
| iss_ready | output | 1 | A free entry exists; issue is accepted when both valid and ready are high |
| iss_base | input | ADDR_W | Base part of the store address |
| iss_offset | input | ADDR_W | Offset part of the store address |
| iss_data | input | DATA_W | Store value, used when `iss_tag` is 0 |
| iss_tag | input | TAG_W | Producer station tag of the value, 0 if the value is present |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the station sourcing the broadcast result |
| bc_data | input | DATA_W | Broadcast result value |
| mem_valid | output | 1 | Oldest store requests a memory write |
| mem_ack | input | 1 | Memory accepts the current write |
| mem_addr | output | ADDR_W | Effective write address |
| mem_data | output | DATA_W | Write value |

## Verification
On every cycle, the bound checker confirms four behaviours. The write request and its address and data stay steady while unacknowledged. A stalled issue port means every entry is busy. A request only comes from an occupied head whose tag is cleared. The presented address equals the sum of the head's stored parts. Other properties need scenarios from the bench. These are value capture from a matching broadcast, including the same-cycle case, and rejection of foreign tags. The bench also shows the drain order among mixed waiting and ready stores, discarding of issues into a full buffer, and the two-edge latency from issue to request.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_DATA_W = 64;
    localparam int unsigned SB_TAG_W  = 4;
    localparam int unsigned SB_ADDR_W = 32;
    localparam int unsigned SB_DEPTH  = 4;

    // Lifecycle of one store slot
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_NEEDEA = 2'd1,
        SLOT_PARKED = 2'd2
    } slot_state_e;

    // Circular pointer advance
    function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/sb_agen.sv
module sb_agen #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] ea
);
    // Shared effective-address adder, result truncated to ADDR_W
    always_comb ea = base + offset;
endmodule

// File: rtl/sb_slot.sv
module sb_slot
    import sb_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] a_base,
    input  logic [ADDR_W-1:0] a_off,
    input  logic [DATA_W-1:0] a_data,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic              ea_load,
    input  logic [ADDR_W-1:0] ea_value,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    input  logic              retire,
    output logic              busy,
    output logic              ea_ok,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] off,
    output logic [ADDR_W-1:0] ea,
    output logic [DATA_W-1:0] value,
    output logic [TAG_W-1:0]  qi
);
    slot_state_e st;
    logic        iss_hit;
    logic        snoop_hit;

    always_comb begin
        iss_hit   = (a_tag != '0) && bc_valid && (bc_tag == a_tag);
        snoop_hit = (st != SLOT_FREE) && (qi != '0) && bc_valid && (bc_tag == qi);
        busy      = (st != SLOT_FREE);
        ea_ok     = (st == SLOT_PARKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SLOT_FREE;
            base  <= '0;
            off   <= '0;
            ea    <= '0;
            value <= '0;
            qi    <= '0;
        end else if (retire) begin
            st <= SLOT_FREE;
            qi <= '0;
        end else if (alloc) begin
            st   <= SLOT_NEEDEA;
            base <= a_base;
            off  <= a_off;
            if (iss_hit) begin
                value <= bc_data;
                qi    <= '0;
            end else begin
                value <= a_data;
                qi    <= a_tag;
            end
        end else begin
            if (ea_load && st == SLOT_NEEDEA) begin
                ea <= ea_value;
                st <= SLOT_PARKED;
            end
            if (snoop_hit) begin
                value <= bc_data;
                qi    <= '0;
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_fire,
    input  logic             agen_fire,
    input  logic             wr_fire,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] aptr,
    output logic             full
);
    logic [CNT_W-1:0] count;

    always_comb full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            aptr  <= '0;
            count <= '0;
        end else begin
            if (iss_fire)  tail <= IDX_W'(ring_next(int'(tail), DEPTH));
            if (agen_fire) aptr <= IDX_W'(ring_next(int'(aptr), DEPTH));
            if (wr_fire)   head <= IDX_W'(ring_next(int'(head), DEPTH));
            case ({iss_fire, wr_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned DATA_W = SB_DATA_W,
    parameter int unsigned TAG_W  = SB_TAG_W,
    parameter int unsigned ADDR_W = SB_ADDR_W,
    parameter int unsigned DEPTH  = SB_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [ADDR_W-1:0] iss_base,
    input  logic [ADDR_W-1:0] iss_offset,
    input  logic [DATA_W-1:0] iss_data,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              mem_valid,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  head, tail, aptr;
    logic              full, iss_fire, agen_fire, wr_fire;
    logic [DEPTH-1:0]  busy_vec, aok_vec;
    logic [ADDR_W-1:0] base_a [DEPTH];
    logic [ADDR_W-1:0] off_a  [DEPTH];
    logic [ADDR_W-1:0] ea_a   [DEPTH];
    logic [DATA_W-1:0] val_a  [DEPTH];
    logic [TAG_W-1:0]  qi_a   [DEPTH];
    logic [ADDR_W-1:0] agen_ea;
    logic [ADDR_W-1:0] head_base, head_off;
    logic [TAG_W-1:0]  head_qi;
    logic              head_busy;

    always_comb begin
        iss_ready = !full;
        iss_fire  = iss_valid && !full;
        agen_fire = busy_vec[aptr] && !aok_vec[aptr];
        head_busy = busy_vec[head];
        head_qi   = qi_a[head];
        head_base = base_a[head];
        head_off  = off_a[head];
        mem_valid = head_busy && aok_vec[head] && (head_qi == '0);
        wr_fire   = mem_valid && mem_ack;
        mem_addr  = ea_a[head];
        mem_data  = val_a[head];
    end

    sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .iss_fire  (iss_fire),
        .agen_fire (agen_fire),
        .wr_fire   (wr_fire),
        .head      (head),
        .tail      (tail),
        .aptr      (aptr),
        .full      (full)
    );

    sb_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base   (base_a[aptr]),
        .offset (off_a[aptr]),
        .ea     (agen_ea)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sb_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .alloc    (iss_fire && (tail == IDX_W'(i))),
            .a_base   (iss_base),
            .a_off    (iss_offset),
            .a_data   (iss_data),
            .a_tag    (iss_tag),
            .ea_load  (agen_fire && (aptr == IDX_W'(i))),
            .ea_value (agen_ea),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_data  (bc_data),
            .retire   (wr_fire && (head == IDX_W'(i))),
            .busy     (busy_vec[i]),
            .ea_ok    (aok_vec[i]),
            .base     (base_a[i]),
            .off      (off_a[i]),
            .ea       (ea_a[i]),
            .value    (val_a[i]),
            .qi       (qi_a[i])
        );
    end
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              mem_valid,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic [DEPTH-1:0]  busy_vec,
    input logic              head_busy,
    input logic [TAG_W-1:0]  head_qi,
    input logic [ADDR_W-1:0] head_base,
    input logic [ADDR_W-1:0] head_off
);
    // R1: idle and open right after reset is released
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (iss_ready && !mem_valid));

    // R8: an unaccepted request holds steady
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R9: stall only when every slot is taken
    p_full_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |-> (&busy_vec));

    // R7 / R4: only an occupied head with its value present may write
    p_head_ready_r7: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (head_busy && head_qi == '0));

    // R2: presented address is the sum of the stored parts
    p_addr_sum_r2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr == ADDR_W'(head_base + head_off)));
endmodule

bind store_buffer sb_chk #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .mem_valid (mem_valid),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .busy_vec  (busy_vec),
    .head_busy (head_busy),
    .head_qi   (head_qi),
    .head_base (head_base),
    .head_off  (head_off)
);

// File: tb/sim_store_buffer.sv
module sim_store_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int TW = 4;
    localparam int AW = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic          iss_ready;
    logic [AW-1:0] iss_base = '0;
    logic [AW-1:0] iss_offset = '0;
    logic [DW-1:0] iss_data = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_data = '0;
    logic          mem_valid;
    logic          mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_buffer #(.DATA_W(DW), .TAG_W(TW), .ADDR_W(AW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_base(iss_base), .iss_offset(iss_offset),
        .iss_data(iss_data), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .mem_valid(mem_valid), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    int errors = 0;
    int checks = 0;
    int cyc_n = 0;
    int ack_mode = 0;          // 0 always, 1 every third cycle, 2 never
    int wr_ptr = 0;
    int rd_ptr = 0;
    bit done = 0;
    bit hold_pend = 0;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic [AW-1:0] exp_addr [256];
    logic [DW-1:0] exp_data [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: falling-edge monitor, then default inputs for the next edge
    task automatic cyc();
        bit ack;
        @(negedge clk);
        cyc_n++;
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
        if (hold_pend) begin
            chk(mem_valid && mem_addr == hold_addr && mem_data == hold_data,
                "R8", "request held while unacknowledged",
                {mem_addr, mem_data[31:0]}, {hold_addr, hold_data[31:0]});
            hold_pend = 0;
        end
        ack = (ack_mode == 0) || (ack_mode == 1 && (cyc_n % 3 == 0));
        if (mem_valid) begin
            if (ack) begin
                if (rd_ptr >= wr_ptr) begin
                    chk(1'b0, "R9", "unexpected memory write", mem_data, '0);
                end else begin
                    chk(mem_addr == exp_addr[rd_ptr], "R2 R7", "write address",
                        DW'(mem_addr), DW'(exp_addr[rd_ptr]));
                    chk(mem_data == exp_data[rd_ptr], "R3 R4 R7", "write data",
                        mem_data, exp_data[rd_ptr]);
                    rd_ptr++;
                end
            end else begin
                hold_pend = 1;
                hold_addr = mem_addr;
                hold_data = mem_data;
            end
        end
        mem_ack = ack;
    endtask

    task automatic issue(input logic [AW-1:0] b, input logic [AW-1:0] o,
                         input logic [DW-1:0] d, input logic [TW-1:0] t,
                         input logic [DW-1:0] expect_d);
        cyc();
        while (!iss_ready) cyc();
        iss_valid  = 1'b1;
        iss_base   = b;
        iss_offset = o;
        iss_data   = d;
        iss_tag    = t;
        exp_addr[wr_ptr] = b + o;
        exp_data[wr_ptr] = expect_d;
        wr_ptr++;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
        cyc();
        bc_valid = 1'b1;
        bc_tag   = t;
        bc_data  = d;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((rd_ptr < wr_ptr || mem_valid) && n < 200) begin
            cyc();
            n++;
        end
        chk(rd_ptr == wr_ptr, req, "all issued stores written",
            DW'(rd_ptr), DW'(wr_ptr));
    endtask

    initial begin
        bit stayed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(iss_ready == 1'b1, "R1", "iss_ready after reset", DW'(iss_ready), 1);
        chk(mem_valid == 1'b0, "R1", "mem_valid after reset", DW'(mem_valid), 0);

        // R2 R3: address sweep with wrap, values present at issue
        ack_mode = 0;
        for (int bi = 0; bi < 6; bi++) begin
            for (int oi = 0; oi < 4; oi++) begin
                logic [AW-1:0] b, o;
                logic [DW-1:0] d;
                b = (bi % 2 == 1) ? (32'hFFFF_FFF0 - AW'(bi)) : AW'(bi) * 32'h1357_0000;
                o = (oi == 3) ? 32'hFFFF_FFFF : AW'(oi) * 32'h18;
                d = 64'hA5A5_0000_0000_0000 ^ DW'(bi * 16 + oi);
                issue(b, o, d, '0, d);
            end
        end
        drain("R2");

        // R10: issue-to-request latency into an empty buffer
        issue(32'h100, 32'h4, 64'h1010, '0, 64'h1010);
        cyc();
        chk(mem_valid == 1'b0, "R10", "no request one edge after issue", DW'(mem_valid), 0);
        cyc();
        chk(mem_valid == 1'b1, "R10", "request two edges after issue", DW'(mem_valid), 1);
        drain("R10");

        // R4 R5 R7: waiting head blocks a ready younger store
        issue(32'h2000, 32'h8, 64'hDEAD, 4'd3, 64'h3333_4444_5555_6666);
        issue(32'h3000, 32'h0, 64'hBEEF, 4'd0, 64'hBEEF);
        stayed = 1;
        repeat (6) begin cyc(); if (mem_valid) stayed = 0; end
        chk(stayed, "R7", "ready younger store does not overtake", DW'(stayed), 1);
        bcast(4'd5, 64'hFFFF_0000_FFFF_0000);
        stayed = 1;
        repeat (4) begin cyc(); if (mem_valid) stayed = 0; end
        chk(stayed, "R5", "foreign tag leaves entry waiting", DW'(stayed), 1);
        bcast(4'd3, 64'h3333_4444_5555_6666);
        drain("R4");

        // R4 R7: four waiting stores, broadcasts in reverse order
        for (int t = 1; t <= 4; t++)
            issue(AW'(t) * 32'h40, 32'h4, 64'h0, TW'(t), 64'hD000 + DW'(t));
        for (int t = 4; t >= 1; t--)
            bcast(TW'(t), 64'hD000 + DW'(t));
        drain("R7");

        // R4: one broadcast feeds two stores sharing a tag
        issue(32'h500, 32'h0, 64'h0, 4'd6, 64'h6666);
        issue(32'h504, 32'h0, 64'h0, 4'd6, 64'h6666);
        bcast(4'd6, 64'h6666);
        drain("R4");

        // R6: broadcast in the issue cycle
        issue(32'h700, 32'h10, 64'h0, 4'd7, 64'h7777_7777);
        bc_valid = 1'b1;
        bc_tag   = 4'd7;
        bc_data  = 64'h7777_7777;
        drain("R6");

        // R9: fill, attempt extra issue, then drain
        ack_mode = 2;
        for (int k = 0; k < DEPTH; k++)
            issue(32'h900 + AW'(k) * 8, 32'h0, 64'h9000 + DW'(k), '0, 64'h9000 + DW'(k));
        cyc();
        chk(iss_ready == 1'b0, "R9", "stall with all entries busy", DW'(iss_ready), 0);
        repeat (4) begin
            cyc();
            iss_valid  = 1'b1;
            iss_base   = 32'hBAD0;
            iss_offset = 32'h0;
            iss_data   = 64'hBAD;
            iss_tag    = '0;
        end
        cyc();
        ack_mode = 0;
        drain("R9");
        repeat (4) cyc();
        chk(mem_valid == 1'b0, "R9", "discarded issue never written", DW'(mem_valid), 0);

        // R8: slow acknowledge with a mix of ready and waiting stores
        ack_mode = 1;
        issue(32'hA00, 32'h1, 64'hA1, '0, 64'hA1);
        issue(32'hA10, 32'h2, 64'h0, 4'd9, 64'hA2A2);
        issue(32'hA20, 32'h3, 64'hA3, '0, 64'hA3);
        bcast(4'd9, 64'hA2A2);
        drain("R8");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule